// File: doc/BRIEF.md
# Shared Stream Miss Table

A small fully associative table placed between a group of read streams and the memory port. Each read request carries a line tag, the id of the requesting stream and the id of the buffer slot inside that stream that will hold the line. A request that finds no live entry takes a table entry and sends one line read to memory. A request that finds an entry still waiting for memory is merged into it and sends nothing. A request that finds an entry already holding its data is served from the table with no memory access.

Each entry records which streams wait on it and which slots inside those streams wait on it. When the line returns, a single broadcast on the response bus carries the data with one write enable per stream and one per slot. Every waiting slot is written at once, so the streams do no tag check of their own. Two slots of one stream that asked for the same line are both listed and both written. Write-stream requests pass through the table: they patch the stored copy of a resident line and are always forwarded to memory.

The default configuration has 16 entries, 4 streams of 4 slots and lines of 8 words of 32 bits. One request is taken per cycle.

Top module: `stream_miss_table`

## Requirements
- R1: After reset no entry is live, `bc_valid` is 0, and with no request presented `mem_req_valid` is 0.
- R2: A read that matches no live entry is accepted only when some entry is not pending and `mem_req_ready` is 1. In that same cycle it drives `mem_req_valid`=1, `mem_req_we`=0, `mem_req_tag` = the request tag and `mem_req_id` = the chosen entry. The entry is chosen round-robin: the first non-pending entry at or after the one following the last entry allocated, starting from entry 0 after reset.
- R3: A read that matches a pending entry is accepted without regard to `mem_req_ready` and makes no memory request. It adds its stream and slot to that entry's waiters.
- R4: One cycle after `mem_rsp_valid` for entry k, `bc_valid`=1 and `bc_data` = the returned line. `bc_stream_en` bit s is set for each waiting stream s, and `bc_slot_en` bit s*E+e is set for each waiting slot e of stream s. Entry k then holds the line, and its waiter lists are empty.
- R5: Two slots of the same stream that asked for the same line both appear in `bc_slot_en` of the single broadcast.
- R6: A read that matches a resident, non-pending entry makes no memory request. One cycle later it gives a broadcast of the stored line with exactly its own stream bit and slot bit set.
- R7: A read that would be served from a resident entry is held (`req_ready`=0) in any cycle in which `mem_rsp_valid` is 1.
- R8: A read that merges into entry k in the same cycle that k's response arrives is included in that response's broadcast.
- R9: A write (`req_write`=1) is accepted exactly when `mem_req_ready` is 1. In that cycle it drives `mem_req_valid`=1, `mem_req_we`=1, and tag, word index and data equal to the request. When its tag is resident it replaces word `req_word` (word w occupies bits w*32 up to w*32+31 of the line) in the stored line. It makes no broadcast.
- R10: When every entry is pending, a read matching no entry is held and makes no memory request, while reads that merge are still accepted.
- R11: With `mem_req_ready`=0, reads that miss and writes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write-through word, 0 = line read |
| req_tag | input | TAG_W | Line tag |
| req_stream | input | log2(NUM_STREAMS) | Requesting stream |
| req_slot | input | log2(STREAM_SLOTS) | Target slot inside the stream (reads) |
| req_word | input | log2(LINE_WORDS) | Word index (writes) |
| req_wdata | input | WORD_W | Write data |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_tag | output | TAG_W | Line tag to memory |
| mem_req_id | output | log2(NUM_ENTRIES) | Table entry for the read |
| mem_req_word | output | log2(LINE_WORDS) | Word index of a write |
| mem_req_data | output | WORD_W | Write data |
| mem_rsp_valid | input | 1 | Memory line returns |
| mem_rsp_id | input | log2(NUM_ENTRIES) | Entry the line belongs to |
| mem_rsp_data | input | LINE_WORDS*WORD_W | Returned line |
| bc_valid | output | 1 | Broadcast to streams |
| bc_stream_en | output | NUM_STREAMS | Per-stream write enable |
| bc_slot_en | output | NUM_STREAMS*STREAM_SLOTS | Per-slot write enable, bit s*E+e |
| bc_data | output | LINE_WORDS*WORD_W | Broadcast line |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a memory return and a new read that merges into the very entry being filled. The bench provokes it by presenting the merge on the cycle the response for that entry arrives, and it requires the merging slot to show up in the same broadcast. The second pair is a memory return and a read that would be served from stored data, which compete for the single broadcast bus. The bench presents such a read on a response cycle and requires it to be held, then retries it later and checks that it is served with only its own enable bits.

// File: rtl/smt_pkg.sv
package smt_pkg;
   typedef enum logic [1:0] {
      BC_NONE  = 2'd0,
      BC_FILL  = 2'd1,
      BC_REUSE = 2'd2
   } bc_src_e;
endpackage

// File: rtl/smt_match.sv
module smt_match #(
   parameter int N     = 16,
   parameter int TAG_W = 26,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [TAG_W-1:0] tags [N],
   input  logic [N-1:0]     live,
   input  logic [TAG_W-1:0] key,
   output logic             hit_any,
   output logic [IDX_W-1:0] hit_idx
);
   logic [N-1:0] hit_vec;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_cmp
         assign hit_vec[gi] = live[gi] && (tags[gi] == key);
      end
   endgenerate

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit_any = |hit_vec;

   always_comb begin
      assert ($onehot0(hit_vec)) else $error("p_unique_match_r3: two live entries share a tag");
   end
endmodule

// File: rtl/smt_rr_pick.sv
module smt_rr_pick #(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     free_vec,
   input  logic [IDX_W-1:0] start,
   output logic             found,
   output logic [IDX_W-1:0] pick
);
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(start) + k) % N;
         if (!found && free_vec[j]) begin
            found = 1'b1;
            pick  = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/stream_miss_table.sv
module stream_miss_table
   import smt_pkg::*;
#(
   parameter int NUM_ENTRIES  = 16,
   parameter int NUM_STREAMS  = 4,
   parameter int STREAM_SLOTS = 4,
   parameter int LINE_WORDS   = 8,
   parameter int WORD_W       = 32,
   parameter int TAG_W        = 26,
   localparam int SID_W  = $clog2(NUM_STREAMS),
   localparam int EID_W  = $clog2(STREAM_SLOTS),
   localparam int IDX_W  = $clog2(NUM_ENTRIES),
   localparam int WID_W  = $clog2(LINE_WORDS),
   localparam int LINE_W = LINE_WORDS * WORD_W,
   localparam int SLOT_N = NUM_STREAMS * STREAM_SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [SID_W-1:0]  req_stream,
   input  logic [EID_W-1:0]  req_slot,
   input  logic [WID_W-1:0]  req_word,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [TAG_W-1:0]  mem_req_tag,
   output logic [IDX_W-1:0]  mem_req_id,
   output logic [WID_W-1:0]  mem_req_word,
   output logic [WORD_W-1:0] mem_req_data,
   input  logic              mem_rsp_valid,
   input  logic [IDX_W-1:0]  mem_rsp_id,
   input  logic [LINE_W-1:0] mem_rsp_data,
   output logic              bc_valid,
   output logic [NUM_STREAMS-1:0] bc_stream_en,
   output logic [SLOT_N-1:0] bc_slot_en,
   output logic [LINE_W-1:0] bc_data
);
   generate
      if (NUM_ENTRIES < 2)  begin : g_bad_entries $error("NUM_ENTRIES must be at least 2"); end
      if (NUM_STREAMS < 2)  begin : g_bad_streams $error("NUM_STREAMS must be at least 2"); end
      if (STREAM_SLOTS < 2) begin : g_bad_slots   $error("STREAM_SLOTS must be at least 2"); end
      if (LINE_WORDS < 2)   begin : g_bad_words   $error("LINE_WORDS must be at least 2"); end
   endgenerate

   // entry state
   logic [TAG_W-1:0]       ent_tag   [NUM_ENTRIES];
   logic [LINE_W-1:0]      ent_data  [NUM_ENTRIES];
   logic [NUM_STREAMS-1:0] ent_smask [NUM_ENTRIES];
   logic [SLOT_N-1:0]      ent_emask [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] ent_pend, ent_valid;
   logic [IDX_W-1:0]       rr_ptr;

   // lookup and allocation
   logic             hit_any, alloc_any;
   logic [IDX_W-1:0] hit_idx, alloc_idx;

   smt_match #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_match (
      .tags(ent_tag), .live(ent_pend | ent_valid), .key(req_tag),
      .hit_any(hit_any), .hit_idx(hit_idx)
   );

   smt_rr_pick #(.N(NUM_ENTRIES)) u_pick (
      .free_vec(~ent_pend), .start(rr_ptr), .found(alloc_any), .pick(alloc_idx)
   );

   logic hit_pend, hit_stored, is_rd, fire, rd_fire;
   logic [NUM_STREAMS-1:0] req_sbit;
   logic [SLOT_N-1:0]      req_ebit;

   assign hit_pend   = hit_any && ent_pend[hit_idx];
   assign hit_stored = hit_any && ent_valid[hit_idx] && !ent_pend[hit_idx];
   assign is_rd      = req_valid && !req_write;
   assign req_sbit   = NUM_STREAMS'(1) << req_stream;
   assign req_ebit   = SLOT_N'(1) << (int'(req_stream) * STREAM_SLOTS + int'(req_slot));

   always_comb begin
      if (req_write)       req_ready = mem_req_ready;
      else if (hit_pend)   req_ready = 1'b1;
      else if (hit_stored) req_ready = !mem_rsp_valid;
      else                 req_ready = alloc_any && mem_req_ready;
   end

   assign fire    = req_valid && req_ready;
   assign rd_fire = fire && !req_write;

   // memory request port
   assign mem_req_valid = req_valid && (req_write || (!hit_any && alloc_any));
   assign mem_req_we    = req_write;
   assign mem_req_tag   = req_tag;
   assign mem_req_id    = alloc_idx;
   assign mem_req_word  = req_word;
   assign mem_req_data  = req_wdata;

   // per-entry update
   genvar ge;
   generate
      for (ge = 0; ge < NUM_ENTRIES; ge++) begin : g_ent
         logic alloc_here, fill_here, merge_here, wr_here;
         assign alloc_here = rd_fire && !hit_any && (alloc_idx == IDX_W'(ge));
         assign fill_here  = mem_rsp_valid && (mem_rsp_id == IDX_W'(ge));
         assign merge_here = rd_fire && hit_pend && (hit_idx == IDX_W'(ge));
         assign wr_here    = fire && req_write && hit_stored && (hit_idx == IDX_W'(ge));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_tag[ge]   <= '0;
               ent_data[ge]  <= '0;
               ent_smask[ge] <= '0;
               ent_emask[ge] <= '0;
               ent_pend[ge]  <= 1'b0;
               ent_valid[ge] <= 1'b0;
            end else begin
               if (alloc_here) begin
                  ent_tag[ge]   <= req_tag;
                  ent_pend[ge]  <= 1'b1;
                  ent_valid[ge] <= 1'b0;
                  ent_smask[ge] <= req_sbit;
                  ent_emask[ge] <= req_ebit;
               end else if (fill_here) begin
                  ent_data[ge]  <= mem_rsp_data;
                  ent_pend[ge]  <= 1'b0;
                  ent_valid[ge] <= 1'b1;
                  ent_smask[ge] <= '0;
                  ent_emask[ge] <= '0;
               end else if (merge_here) begin
                  ent_smask[ge] <= ent_smask[ge] | req_sbit;
                  ent_emask[ge] <= ent_emask[ge] | req_ebit;
               end
               if (wr_here) begin
                  ent_data[ge][int'(req_word)*WORD_W +: WORD_W] <= req_wdata;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) rr_ptr <= '0;
      else if (rd_fire && !hit_any)
         rr_ptr <= (alloc_idx == IDX_W'(NUM_ENTRIES - 1)) ? '0 : alloc_idx + IDX_W'(1);
   end

   // broadcast bus
   bc_src_e bc_src;
   logic    merge_on_fill;
   assign merge_on_fill = rd_fire && hit_pend && (hit_idx == mem_rsp_id);

   always_comb begin
      if (mem_rsp_valid)                  bc_src = BC_FILL;
      else if (rd_fire && hit_stored)     bc_src = BC_REUSE;
      else                                bc_src = BC_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bc_valid     <= 1'b0;
         bc_stream_en <= '0;
         bc_slot_en   <= '0;
         bc_data      <= '0;
      end else begin
         case (bc_src)
            BC_FILL: begin
               bc_valid     <= 1'b1;
               bc_stream_en <= ent_smask[mem_rsp_id] | (merge_on_fill ? req_sbit : '0);
               bc_slot_en   <= ent_emask[mem_rsp_id] | (merge_on_fill ? req_ebit : '0);
               bc_data      <= mem_rsp_data;
            end
            BC_REUSE: begin
               bc_valid     <= 1'b1;
               bc_stream_en <= req_sbit;
               bc_slot_en   <= req_ebit;
               bc_data      <= ent_data[hit_idx];
            end
            default: begin
               bc_valid     <= 1'b0;
               bc_stream_en <= '0;
               bc_slot_en   <= '0;
            end
         endcase
      end
   end

   // properties
   p_bc_after_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |=> bc_valid && (bc_stream_en != '0));

   p_rsp_targets_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> ent_pend[mem_rsp_id]);

   p_merge_no_memreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && hit_pend) |-> (req_ready && !mem_req_valid));

   p_reuse_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && hit_stored && mem_rsp_valid) |-> !req_ready);

   p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !hit_any && (&ent_pend)) |-> (!req_ready && !mem_req_valid));

   p_write_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_write) |-> (mem_req_valid && mem_req_we));

   p_write_no_bc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_write && !mem_rsp_valid) |=> !bc_valid);

   p_miss_sets_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !hit_any) |=> ent_pend[$past(alloc_idx)]);
endmodule

// File: tb/stream_miss_table_bench.sv
module stream_miss_table_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16, S = 4, E = 4, W = 8, WW = 32, TW = 26;
   localparam int LW = W * WW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          req_valid, req_ready, req_write;
   logic [TW-1:0] req_tag;
   logic [1:0]    req_stream, req_slot;
   logic [2:0]    req_word;
   logic [WW-1:0] req_wdata;
   logic          mem_req_valid, mem_req_ready, mem_req_we;
   logic [TW-1:0] mem_req_tag;
   logic [3:0]    mem_req_id;
   logic [2:0]    mem_req_word;
   logic [WW-1:0] mem_req_data;
   logic          mem_rsp_valid;
   logic [3:0]    mem_rsp_id;
   logic [LW-1:0] mem_rsp_data;
   logic          bc_valid;
   logic [S-1:0]  bc_stream_en;
   logic [S*E-1:0] bc_slot_en;
   logic [LW-1:0] bc_data;

   stream_miss_table u_stream_miss_table (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_tag(req_tag), .req_stream(req_stream), .req_slot(req_slot),
      .req_word(req_word), .req_wdata(req_wdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_tag(mem_req_tag), .mem_req_id(mem_req_id),
      .mem_req_word(mem_req_word), .mem_req_data(mem_req_data),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id), .mem_rsp_data(mem_rsp_data),
      .bc_valid(bc_valid), .bc_stream_en(bc_stream_en), .bc_slot_en(bc_slot_en),
      .bc_data(bc_data)
   );

   int checks = 0;
   int errors = 0;
   logic [S-1:0]   exp_s [N];
   logic [S*E-1:0] exp_e [N];

   task automatic check(input bit ok, input string what, input logic [LW-1:0] act,
                        input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] line_of(input int i);
      logic [LW-1:0] l;
      for (int w = 0; w < W; w++) l[w*WW +: WW] = 32'hA000_0000 | (i << 8) | w;
      return l;
   endfunction

   task automatic idle();
      req_valid = 0; req_write = 0; mem_rsp_valid = 0;
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic set_rd(input int tag, input int s, input int sl);
      req_valid = 1; req_write = 0; req_tag = TW'(tag);
      req_stream = 2'(s); req_slot = 2'(sl);
   endtask

   task automatic set_wr(input int tag, input int w, input logic [WW-1:0] d);
      req_valid = 1; req_write = 1; req_tag = TW'(tag); req_word = 3'(w); req_wdata = d;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [LW-1:0] l;
      idle();
      req_tag = '0; req_stream = '0; req_slot = '0; req_word = '0; req_wdata = '0;
      mem_req_ready = 1; mem_rsp_id = '0; mem_rsp_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(bc_valid == 0, "R1 bc_valid after reset", LW'(bc_valid), 0);
      check(mem_req_valid == 0, "R1 mem_req_valid idle", LW'(mem_req_valid), 0);

      // fill every entry with a miss
      for (int i = 0; i < N; i++) begin
         int s, sl;
         s = i % S; sl = (i / S) % E;
         set_rd(100 + i, s, sl);
         #1;
         check(req_ready == 1, "R2 miss accepted", LW'(req_ready), 1);
         check(mem_req_valid && !mem_req_we, "R2 miss mem read", LW'({mem_req_valid, mem_req_we}), 2);
         check(mem_req_id == 4'(i), "R2 round-robin id", LW'(mem_req_id), LW'(i));
         check(mem_req_tag == TW'(100 + i), "R2 miss tag", LW'(mem_req_tag), LW'(100 + i));
         exp_s[i] = S'(1) << s;
         exp_e[i] = (S*E)'(1) << (s * E + sl);
         tick(); idle();
         check(bc_valid == 0, "R2 no broadcast on miss", LW'(bc_valid), 0);
      end

      // full table
      set_rd(500, 0, 0);
      #1;
      check(req_ready == 0, "R10 full miss held", LW'(req_ready), 0);
      check(mem_req_valid == 0, "R10 full no mem req", LW'(mem_req_valid), 0);
      idle();

      // merges
      set_rd(103, 1, 2);
      #1;
      check(req_ready == 1, "R10 merge accepted when full", LW'(req_ready), 1);
      check(mem_req_valid == 0, "R3 merge no mem req", LW'(mem_req_valid), 0);
      exp_s[3] |= 4'b0010; exp_e[3] |= 16'h0040;
      tick(); idle();
      mem_req_ready = 0;
      set_rd(105, 1, 3);
      #1;
      check(req_ready == 1, "R3 merge independent of mem ready", LW'(req_ready), 1);
      check(mem_req_valid == 0, "R5 same-stream merge no mem req", LW'(mem_req_valid), 0);
      exp_e[5] |= 16'h0080;
      tick(); idle();
      mem_req_ready = 1;

      // returns
      for (int i = 0; i < N; i++) begin
         mem_rsp_valid = 1; mem_rsp_id = 4'(i); mem_rsp_data = line_of(i);
         if (i == 7) begin
            set_rd(107, 2, 0);
            exp_s[7] |= 4'b0100; exp_e[7] |= 16'h0100;
         end
         if (i == 9) set_rd(100, 0, 0);
         #1;
         if (i == 7) check(req_ready == 1, "R8 merge on fill cycle accepted", LW'(req_ready), 1);
         if (i == 9) check(req_ready == 0, "R7 reuse held during response", LW'(req_ready), 0);
         tick(); idle();
         check(bc_valid == 1, "R4 broadcast valid", LW'(bc_valid), 1);
         check(bc_stream_en == exp_s[i], (i == 7) ? "R8 stream enables" : "R4 stream enables",
               LW'(bc_stream_en), LW'(exp_s[i]));
         check(bc_slot_en == exp_e[i],
               (i == 5) ? "R5 both slots" : (i == 7) ? "R8 slot enables" : "R4 slot enables",
               LW'(bc_slot_en), LW'(exp_e[i]));
         check(bc_data == line_of(i), "R4 broadcast data", bc_data, line_of(i));
      end
      tick();
      check(bc_valid == 0, "R4 broadcast is one cycle", LW'(bc_valid), 0);

      // reuse from stored lines
      for (int i = 0; i < N; i++) begin
         int s, sl;
         s = (i + 1) % S; sl = (i + 2) % E;
         set_rd(100 + i, s, sl);
         #1;
         check(req_ready == 1 && mem_req_valid == 0, "R6 reuse no mem req",
               LW'({req_ready, mem_req_valid}), 2);
         tick(); idle();
         check(bc_valid == 1, "R6 reuse broadcast", LW'(bc_valid), 1);
         check(bc_stream_en == S'(1) << s, "R6 reuse stream bit", LW'(bc_stream_en), LW'(1 << s));
         check(bc_slot_en == (S*E)'(1) << (s * E + sl), "R6 reuse slot bit",
               LW'(bc_slot_en), LW'(1 << (s * E + sl)));
         check(bc_data == line_of(i), "R6 reuse data", bc_data, line_of(i));
      end

      // write-through
      set_wr(104, 3, 32'h1234_5678);
      #1;
      check(req_ready == 1, "R9 write accepted", LW'(req_ready), 1);
      check(mem_req_valid && mem_req_we, "R9 write forwarded", LW'({mem_req_valid, mem_req_we}), 3);
      check(mem_req_tag == TW'(104) && mem_req_word == 3'd3 && mem_req_data == 32'h1234_5678,
            "R9 write fields", LW'({mem_req_tag, mem_req_word, mem_req_data}),
            LW'({TW'(104), 3'd3, 32'h1234_5678}));
      tick(); idle();
      check(bc_valid == 0, "R9 write no broadcast", LW'(bc_valid), 0);
      set_rd(104, 0, 0);
      tick(); idle();
      l = line_of(4); l[3*WW +: WW] = 32'h1234_5678;
      check(bc_data == l, "R9 stored word updated", bc_data, l);

      // memory not ready
      mem_req_ready = 0;
      set_wr(104, 0, 32'hDEAD_BEEF);
      #1;
      check(req_ready == 0, "R11 write held", LW'(req_ready), 0);
      set_rd(900, 0, 0);
      #1;
      check(req_ready == 0, "R11 miss held", LW'(req_ready), 0);
      idle();
      mem_req_ready = 1;

      // round-robin wraps after last allocation of entry 15
      set_rd(900, 0, 0);
      #1;
      check(mem_req_valid && mem_req_id == 4'd0, "R2 round-robin wrap", LW'(mem_req_id), 0);
      tick(); idle();
      set_rd(100, 1, 1);
      #1;
      check(mem_req_valid && mem_req_id == 4'd1, "R2 evicted tag misses", LW'(mem_req_id), 1);
      tick(); idle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule